// File: doc/BRIEF.md
# Multi-Rail Voltage Fault Supervisor

This block supervises a set of power-supply rails from their digitized voltage samples. Every rail carries its own upper and lower voltage limit and its own glitch filter length. A sample outside the limits only becomes an alarm once the excursion has lasted longer than the filter allows. A rail that is switched on but never settles inside its window within a shared start timeout raises a separate no-start alarm.

Each alarm is handled by the rail's own response code. The response can drop the alarm, record it, or turn the rail's supply enable off. Turning a rail off can affect that rail alone, that rail with one timed restart, or every rail at once. Recorded alarms go into a small queue that a host drains one entry at a time. The physical level of each enable follows a per-rail polarity setting. Rails can be excluded from supervision entirely.

Top module: `rail_fault_supervisor`

## Requirements
- R1: After reset the log queue is empty, `log_ovf` is low, and every requested rail drives its on level on `rail_en`.
- R2: A sample violates its window when it is strictly above `ov_thr` (overvoltage) or strictly below `uv_thr` (undervoltage). A sample equal to either limit is inside the window.
- R3: On a started rail, an overvoltage or undervoltage alarm fires on the strobe where the number of consecutive violating strobes first exceeds that rail's `glitch_len`. Any in-window strobe resets the count. One excursion raises at most one alarm.
- R4: A requested, monitored rail counts as started at its first in-window strobe. A no-start alarm fires on the strobe where the count of violating strobes since the rail was switched on first exceeds `start_tmo`. The overvoltage and undervoltage filters run only on started rails.
- R5: A rail whose `monitored` bit is 0 raises no alarm, logs nothing and is never shut down by its own samples.
- R6: Response codes are 3 bits per rail. Code 0 and codes 5 to 7 take no action and log nothing. Code 1 logs the alarm and leaves the enable unchanged.
- R7: Code 4 logs the alarm and holds the rail off until `clr` is pulsed.
- R8: Code 3 logs the alarm and turns the rail off for exactly RETRY_OFF clock cycles before restoring it. Any later alarm on that rail holds it off until `clr`. `clr` also restores the retry.
- R9: Code 2 logs the alarm and holds every rail off until `clr`.
- R10: `rail_en[i]` is high for "on" when `en_high[i]` is 1. It is low for "on" when `en_high[i]` is 0. The opposite level means off. A rail with `rail_req` low is off.
- R11: A log entry holds a 3-bit rail index and a 2-bit type: 01 overvoltage, 10 undervoltage, 11 no-start. The entry is visible at the head one cycle after the alarm strobe. Alarms on the same strobe are queued lowest rail first. `log_pop` removes the head.
- R12: The queue holds LOG_DEPTH entries. An alarm that arrives while the queue is full is dropped and sets `log_ovf`. `log_ovf` stays set until `clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Releases held-off rails, restores retries, clears overflow |
| smp_valid | input | 1 | Strobe marking a new set of samples |
| smp | input | NRAIL*SW | Packed rail samples, rail 0 in the low bits |
| ov_thr | input | NRAIL*SW | Per-rail overvoltage limits |
| uv_thr | input | NRAIL*SW | Per-rail undervoltage limits |
| glitch_len | input | NRAIL*GW | Per-rail glitch filter lengths in strobes |
| policy | input | NRAIL*3 | Per-rail alarm response codes |
| monitored | input | NRAIL | Per-rail supervision enable |
| en_high | input | NRAIL | Per-rail enable polarity, 1 means active-high |
| rail_req | input | NRAIL | Per-rail request to switch on |
| start_tmo | input | GW | No-start timeout in strobes |
| log_pop | input | 1 | Removes the queue head |
| rail_en | output | NRAIL | Supply enables at their physical levels |
| log_valid | output | 1 | Queue not empty |
| log_rail | output | 3 | Rail index of the head entry |
| log_type | output | 2 | Fault type of the head entry |
| log_ovf | output | 1 | An alarm was dropped on a full queue |

## Verification
A wrong filter count shows at the ports on the strobe where the alarm should or should not fire. A bad count moves the `rail_en` change by whole strobes, and the matching log entry follows one cycle later. A wrong retry timer shows up as an off window on `rail_en` that differs from RETRY_OFF cycles, and this is measured edge by edge. A corrupted queue pointer or count shows up as an entry in the wrong order, an entry that is missing or repeated, or `log_ovf` rising before the queue is really full. Each of these is seen at the first pop or the first overflow that follows.

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
  parameter int NRAIL     = 8,
  parameter int SW        = 12,
  parameter int GW        = 16,
  parameter int RETRY_OFF = 1024,
  parameter int LOG_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                smp_valid,
  input  logic [NRAIL*SW-1:0] smp,
  input  logic [NRAIL*SW-1:0] ov_thr,
  input  logic [NRAIL*SW-1:0] uv_thr,
  input  logic [NRAIL*GW-1:0] glitch_len,
  input  logic [NRAIL*3-1:0]  policy,
  input  logic [NRAIL-1:0]    monitored,
  input  logic [NRAIL-1:0]    en_high,
  input  logic [NRAIL-1:0]    rail_req,
  input  logic [GW-1:0]       start_tmo,
  input  logic                log_pop,
  output logic [NRAIL-1:0]    rail_en,
  output logic                log_valid,
  output logic [$clog2(NRAIL)-1:0] log_rail,
  output logic [1:0]          log_type,
  output logic                log_ovf
);
  localparam int RIW = $clog2(NRAIL);
  localparam int TW  = $clog2(RETRY_OFF);
  localparam int LAW = $clog2(LOG_DEPTH);
  localparam int LCW = $clog2(LOG_DEPTH + 1);

  logic [GW-1:0]  gcnt [NRAIL];
  logic [GW-1:0]  scnt [NRAIL];
  logic [TW-1:0]  tmr  [NRAIL];
  logic [1:0]     ptype [NRAIL];
  logic [1:0]     etype [NRAIL];
  logic [NRAIL-1:0] started, latched, retrying, retry_used, pend;
  logic [NRAIL-1:0] on, act, over, under, evt, logs, latch_me, retry_me, seq_v, take;
  logic [RIW-1:0] sel;

  for (genvar i = 0; i < NRAIL; i++) begin : g_rail
    logic [SW-1:0] s;
    logic [2:0]    pc;
    logic          bad, flt, nst;
    assign s   = smp[i*SW +: SW];
    assign pc  = policy[i*3 +: 3];
    assign on[i]    = rail_req[i] & ~latched[i] & ~retrying[i];
    assign act[i]   = monitored[i] & on[i];
    assign over[i]  = s > ov_thr[i*SW +: SW];
    assign under[i] = s < uv_thr[i*SW +: SW];
    assign bad = over[i] | under[i];
    assign flt = smp_valid & act[i] & started[i] & bad & (gcnt[i] == glitch_len[i*GW +: GW]);
    assign nst = smp_valid & act[i] & ~started[i] & bad & (scnt[i] == start_tmo);
    assign evt[i]   = flt | nst;
    assign etype[i] = nst ? 2'b11 : (over[i] ? 2'b01 : 2'b10);
    assign logs[i]     = evt[i] & (pc >= 3'd1) & (pc <= 3'd4);
    assign seq_v[i]    = evt[i] & (pc == 3'd2);
    assign retry_me[i] = evt[i] & (pc == 3'd3) & ~retry_used[i];
    assign latch_me[i] = evt[i] & ((pc == 3'd4) | ((pc == 3'd3) & retry_used[i]));
    assign rail_en[i]  = ~(on[i] ^ en_high[i]);
  end

  assign take = pend & (~pend + 1'b1);

  always_comb begin
    sel = '0;
    for (int i = NRAIL - 1; i >= 0; i--)
      if (pend[i]) sel = RIW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= '0; latched <= '0; retrying <= '0; retry_used <= '0; pend <= '0;
      for (int i = 0; i < NRAIL; i++) begin
        gcnt[i] <= '0; scnt[i] <= '0; tmr[i] <= '0; ptype[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NRAIL; i++) begin
        if (!act[i]) begin
          gcnt[i] <= '0; scnt[i] <= '0; started[i] <= 1'b0;
        end else if (smp_valid) begin
          if (started[i]) begin
            if (!(over[i] | under[i])) gcnt[i] <= '0;
            else if (gcnt[i] != '1)    gcnt[i] <= gcnt[i] + 1'b1;
          end else if (!(over[i] | under[i])) begin
            started[i] <= 1'b1;
          end else if (scnt[i] != '1) begin
            scnt[i] <= scnt[i] + 1'b1;
          end
        end

        if (clr)                            latched[i] <= 1'b0;
        else if (latch_me[i] || (|seq_v))   latched[i] <= 1'b1;

        if (clr)              retry_used[i] <= 1'b0;
        else if (retry_me[i]) retry_used[i] <= 1'b1;

        if (clr) retrying[i] <= 1'b0;
        else if (retry_me[i]) begin
          retrying[i] <= 1'b1;
          tmr[i]      <= TW'(RETRY_OFF - 1);
        end else if (retrying[i]) begin
          if (tmr[i] == '0) retrying[i] <= 1'b0;
          else              tmr[i] <= tmr[i] - 1'b1;
        end

        if (!pend[i] || take[i]) begin
          pend[i]  <= logs[i];
          ptype[i] <= etype[i];
        end
      end
    end
  end

  logic [RIW+1:0] mem [LOG_DEPTH];
  logic [LAW-1:0] wp, rp;
  logic [LCW-1:0] lcnt;
  logic           full, do_push, do_pop;

  assign full    = lcnt == LCW'(LOG_DEPTH);
  assign do_push = (|pend) & ~full;
  assign do_pop  = log_pop & (lcnt != '0);
  assign log_valid = lcnt != '0;
  assign {log_rail, log_type} = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= {sel, ptype[sel]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; lcnt <= '0; log_ovf <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == LAW'(LOG_DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAW'(LOG_DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      lcnt <= lcnt + 1'b1;
      else if (!do_push && do_pop) lcnt <= lcnt - 1'b1;
      if (clr)                  log_ovf <= 1'b0;
      else if ((|pend) && full) log_ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/rail_fault_supervisor_chk.sv
module rail_fault_supervisor_chk #(
  parameter int NRAIL     = 8,
  parameter int LOG_DEPTH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr,
  input logic                log_valid,
  input logic [1:0]          log_type,
  input logic                log_ovf,
  input logic [$clog2(LOG_DEPTH+1)-1:0] lcnt,
  input logic [NRAIL-1:0]    retrying,
  input logic [NRAIL-1:0]    retry_used,
  input logic [NRAIL-1:0]    latched,
  input logic [NRAIL-1:0]    rail_en,
  input logic [NRAIL-1:0]    en_high
);
  assert_fifo_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lcnt <= ($clog2(LOG_DEPTH+1))'(LOG_DEPTH));

  assert_entry_type_R11: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> log_type != 2'b00);

  assert_ovf_on_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_ovf) |-> $past(lcnt) == ($clog2(LOG_DEPTH+1))'(LOG_DEPTH));

  assert_ovf_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !log_ovf);

  for (genvar i = 0; i < NRAIL; i++) begin : g_chk
    assert_single_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(retrying[i]) |-> !$past(retry_used[i]));

    assert_held_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      latched[i] |-> rail_en[i] != en_high[i]);

    assert_retry_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      retrying[i] |-> rail_en[i] != en_high[i]);
  end
endmodule

bind rail_fault_supervisor rail_fault_supervisor_chk #(.NRAIL(NRAIL), .LOG_DEPTH(LOG_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .log_valid(log_valid), .log_type(log_type),
  .log_ovf(log_ovf), .lcnt(lcnt), .retrying(retrying), .retry_used(retry_used),
  .latched(latched), .rail_en(rail_en), .en_high(en_high)
);

// File: tb/rail_fault_supervisor_tb_top.sv
module rail_fault_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NRAIL = 8, SW = 12, GW = 16, RETRY_OFF = 1024, LOG_DEPTH = 8;
  localparam logic [7:0] ALL_ON = 8'hBF;

  logic clk = 0, rst_n = 0, clr = 0, smp_valid = 0, log_pop = 0;
  logic [NRAIL*SW-1:0] smp, ov_thr, uv_thr;
  logic [NRAIL*GW-1:0] glitch_len;
  logic [NRAIL*3-1:0]  policy;
  logic [NRAIL-1:0]    monitored = 8'b1101_1111, en_high = 8'b1011_1111, rail_req = '1;
  logic [GW-1:0]       start_tmo = 16'd4;
  logic [NRAIL-1:0]    rail_en;
  logic                log_valid, log_ovf;
  logic [2:0]          log_rail;
  logic [1:0]          log_type;
  int checks = 0, errs = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_fault_supervisor #(.NRAIL(NRAIL), .SW(SW), .GW(GW), .RETRY_OFF(RETRY_OFF), .LOG_DEPTH(LOG_DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid), .smp(smp), .ov_thr(ov_thr),
    .uv_thr(uv_thr), .glitch_len(glitch_len), .policy(policy), .monitored(monitored),
    .en_high(en_high), .rail_req(rail_req), .start_tmo(start_tmo), .log_pop(log_pop),
    .rail_en(rail_en), .log_valid(log_valid), .log_rail(log_rail), .log_type(log_type), .log_ovf(log_ovf));

  // sample, alarm expected, type
  localparam logic [14:0] VEC [17] = '{
    {12'd2000, 1'b0, 2'b00}, {12'd3500, 1'b0, 2'b00}, {12'd3500, 1'b0, 2'b00},
    {12'd2000, 1'b0, 2'b00}, {12'd3500, 1'b0, 2'b00}, {12'd3500, 1'b0, 2'b00},
    {12'd3500, 1'b1, 2'b01}, {12'd3500, 1'b0, 2'b00}, {12'd2000, 1'b0, 2'b00},
    {12'd500,  1'b0, 2'b00}, {12'd500,  1'b0, 2'b00}, {12'd500,  1'b1, 2'b10},
    {12'd3000, 1'b0, 2'b00}, {12'd1000, 1'b0, 2'b00}, {12'd3001, 1'b0, 2'b00},
    {12'd3001, 1'b0, 2'b00}, {12'd3001, 1'b1, 2'b01}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int n);
    repeat (n) begin
      smp_valid = 1; @(negedge clk); smp_valid = 0;
    end
  endtask

  task automatic set_smp(input int r, input int v);
    smp[r*SW +: SW] = SW'(v);
  endtask

  task automatic pulse_clr();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic pop_expect(input string tag, input int r, input int t);
    check({tag, " log_valid"}, log_valid, 1);
    check({tag, " log_rail"}, log_rail, r);
    check({tag, " log_type"}, log_type, t);
    log_pop = 1; @(negedge clk); log_pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NRAIL; i++) begin
      smp[i*SW +: SW] = 12'd2000; ov_thr[i*SW +: SW] = 12'd3000;
      uv_thr[i*SW +: SW] = 12'd1000; glitch_len[i*GW +: GW] = 16'd2;
    end
    policy = {3'd5, 3'd4, 3'd4, 3'd0, 3'd2, 3'd4, 3'd3, 3'd1};
    idle(3); rst_n = 1; idle(1);
    check("R1 rail_en", rail_en, ALL_ON);
    check("R1 log_valid", log_valid, 0);
    check("R1 log_ovf", log_ovf, 0);
    strobe(1);

    for (int k = 0; k < 17; k++) begin
      set_smp(0, VEC[k][14:3]); strobe(1); idle(2);
      check("R6 log-only keeps rail on", rail_en[0], 1);
      if (VEC[k][2]) pop_expect("R3 R2 vector alarm", 0, VEC[k][1:0]);
      else check("R3 R2 no alarm", log_valid, 0);
    end
    set_smp(0, 2000); strobe(1);

    set_smp(4, 3500); set_smp(5, 3500); set_smp(7, 500);
    strobe(4); idle(2);
    check("R6 ignore codes no log", log_valid, 0);
    check("R5 R6 enables untouched", rail_en, ALL_ON);
    set_smp(4, 2000); set_smp(5, 2000); set_smp(7, 2000); strobe(1);

    policy[21 +: 3] = 3'd1;
    set_smp(7, 500); set_smp(0, 3500); strobe(3); idle(2);
    pop_expect("R11 order first", 0, 1);
    pop_expect("R11 order second", 7, 2);
    check("R11 drained", log_valid, 0);
    set_smp(7, 2000); set_smp(0, 2000); strobe(1); policy[21 +: 3] = 3'd5;

    set_smp(2, 900); strobe(3);
    check("R7 rail off", rail_en, ALL_ON & ~8'h04);
    idle(1); pop_expect("R7 log", 2, 2);
    set_smp(2, 2000); strobe(2); idle(50);
    check("R7 stays off", rail_en[2], 0);
    pulse_clr();
    check("R7 clr restores", rail_en, ALL_ON);
    strobe(1);

    set_smp(6, 3500); strobe(3);
    check("R10 active-low off level", rail_en[6], 1);
    idle(1); pop_expect("R10 log", 6, 1);
    set_smp(6, 2000); pulse_clr(); strobe(1);
    check("R10 active-low on level", rail_en[6], 0);

    set_smp(1, 3500); strobe(3);
    check("R8 retry off", rail_en[1], 0);
    set_smp(1, 2000);
    begin
      int n = 0;
      while (rail_en[1] == 0 && n < 5000) begin @(negedge clk); n++; end
      check("R8 off window cycles", n, RETRY_OFF);
    end
    pop_expect("R8 first log", 1, 1);
    strobe(1);
    set_smp(1, 3500); strobe(3);
    check("R8 second alarm off", rail_en[1], 0);
    idle(1); pop_expect("R8 second log", 1, 1);
    set_smp(1, 2000); idle(1100);
    check("R8 held after second alarm", rail_en[1], 0);
    pulse_clr();
    check("R8 clr restores", rail_en, ALL_ON);
    strobe(1);

    set_smp(3, 3500); strobe(3);
    check("R9 all rails off", rail_en, 8'h40);
    idle(1); pop_expect("R9 log", 3, 1);
    set_smp(3, 2000); idle(5);
    check("R9 still off", rail_en, 8'h40);
    pulse_clr();
    check("R9 clr restores", rail_en, ALL_ON);
    strobe(1);

    rail_req[0] = 0; set_smp(0, 0); strobe(1);
    check("R10 unrequested off", rail_en[0], 0);
    rail_req[0] = 1; strobe(4); idle(2);
    check("R4 no alarm within timeout", log_valid, 0);
    strobe(1); idle(2);
    pop_expect("R4 no-start log", 0, 3);
    check("R4 single no-start", log_valid, 0);
    set_smp(0, 2000); strobe(1);

    for (int f = 0; f < 9; f++) begin
      set_smp(0, 3500); strobe(3); set_smp(0, 2000); strobe(1);
    end
    idle(2);
    check("R12 overflow flag", log_ovf, 1);
    for (int e = 0; e < 8; e++) pop_expect("R12 kept entry", 0, 1);
    check("R12 ninth dropped", log_valid, 0);
    check("R12 flag sticky", log_ovf, 1);
    pulse_clr();
    check("R12 clr clears flag", log_ovf, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule